// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block sits beside a processor core and decides which exception the core should take next. It holds the pending state for one non-maskable input, 32 external interrupt lines and four internal system requests: supervisor call, pendable service, tick and hard fault. It also holds the enable state for the external lines and the tick request, a two-bit priority code for each source whose priority software can change, and a global mask bit.

Every cycle the arbiter picks the best eligible pending source. The lowest priority value wins, and on equal values the lower exception number wins. The winner is compared with the execution priority that the core reports. Exception entry and return, vector fetch and the tick timer belong to the core and its neighbours. The core acknowledges the number it takes, and software programs the block through a flat indexed write port.

Priority levels are 10-bit two's complement values. Non-maskable takes -2 and hard fault takes -1. Programmable levels are 0, 64, 128 and 192. Thread mode is reported as 256, which is lower than every exception level.

Top module: `irq_prio_arb`

## Requirements
- R1: Exception numbers on exc_num_o are 2 for non-maskable, 3 for hard fault, 11 for supervisor call, 14 for pendable service, 15 for tick and 16+k for external line k. The value 1 is reserved for reset and is never produced.
- R2: Non-maskable is reported at level -2 and hard fault at level -1. Neither can be disabled.
- R3: A write to priority index n, where n is 11, 14, 15 or 16+k, keeps only wr_data_i[7:6]. The source's level becomes that code times 64, and wr_data_i[5:0] have no effect on exc_prio_o.
- R4: take_o is 1 only when the winner's level is strictly below cur_prio_i. A winner that is equal or lower is still shown on exc_num_o and exc_prio_o with take_o at 0.
- R5: When several eligible sources share the best level, the lowest exception number is reported.
- R6: An external line or the tick request is eligible only while enabled. Enable bits are set by writing ones to index 0 and cleared by writing ones to index 1 (bit k is line k). The tick enable is set by index 4 bit 3 and cleared by index 4 bit 4. A request that arrives while disabled stays pending and is reported once it is enabled.
- R7: A one-cycle pulse or a held level on irq_i[k] sets pending for line k. Writing ones to index 2 also sets pending, and writing ones to index 3 clears it.
- R8: The mask bit is set by index 4 bit 5 and cleared by index 4 bit 6. While it is set, no source at a level of 0 or above is eligible, but non-maskable and hard fault still are.
- R9: A pending bit cleared by software before it is taken is never reported. Pendable service is set by index 4 bit 0 and cleared by index 4 bit 1, and tick pending is cleared by index 4 bit 2.
- R10: A supervisor call request raised while cur_prio_i is at or above its own priority (numerically cur_prio_i <= its level) pends hard fault instead of the supervisor call.
- R11: An acknowledge of number n clears that source's pending bit in the same edge, and a clear wins over a set arriving on that edge. A level input still high re-pends on the next edge.
- R12: After reset nothing is pending, all enables and the mask are 0 and all priority codes are 0. With no eligible source, exc_num_o is 0, exc_prio_o is 256 and take_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_IRQ | External interrupt lines, active high, level or pulse |
| nmi_i | input | 1 | Non-maskable request, level or pulse |
| hf_req_i | input | 1 | Hard fault request pulse from the core |
| svc_req_i | input | 1 | Supervisor call request pulse from the core |
| tick_req_i | input | 1 | Tick request pulse from the timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | NUM_W | Flat register index |
| wr_data_i | input | 32 | Register write data |
| ack_i | input | 1 | Core takes an exception this cycle |
| ack_num_i | input | NUM_W | Exception number being taken |
| cur_prio_i | input | 10 | Current execution priority, signed, 256 in thread mode |
| take_o | output | 1 | Winner preempts the current priority |
| exc_num_o | output | NUM_W | Winning exception number, 0 when none |
| exc_prio_o | output | 10 | Winning level, signed, 256 when none |

## Verification
The bench walks every external line through the full sequence: latch a pulse while disabled, enable, read number and level, acknowledge, and disable. Each line gets a priority write with garbage in the low bits. A wrong number mapping, a pulse that is lost, or low bits that leak into the level would each show up on the line concerned. All sixteen level pairs for two lines hit together are swept, so a tie-break that favours the higher number or uses a non-strict compare reports the wrong winner. A further set of cases targets four behaviours: strict preemption at cur_prio_i equal to the winner's level, the mask letting non-maskable and hard fault through, supervisor call escalation at the boundary, and a level line re-pending after acknowledge. A design that takes on equality, masks the fixed levels, escalates only on a strict compare, or lets a set beat an acknowledge would fail one of these cases.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LVL_W = 10;
  typedef logic signed [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_NMI  = -10'sd2;
  localparam lvl_t LVL_HF   = -10'sd1;
  localparam lvl_t LVL_NONE = 10'sd256;

  localparam int unsigned EXC_NMI  = 2;
  localparam int unsigned EXC_HF   = 3;
  localparam int unsigned EXC_SVC  = 11;
  localparam int unsigned EXC_PSV  = 14;
  localparam int unsigned EXC_TICK = 15;
  localparam int unsigned EXC_EXT0 = 16;

  localparam int unsigned IDX_ENA_SET = 0;
  localparam int unsigned IDX_ENA_CLR = 1;
  localparam int unsigned IDX_PND_SET = 2;
  localparam int unsigned IDX_PND_CLR = 3;
  localparam int unsigned IDX_SYS     = 4;

  // system control bits at IDX_SYS
  localparam int unsigned SB_PSV_SET  = 0;
  localparam int unsigned SB_PSV_CLR  = 1;
  localparam int unsigned SB_TICK_CLR = 2;
  localparam int unsigned SB_TEN_SET  = 3;
  localparam int unsigned SB_TEN_CLR  = 4;
  localparam int unsigned SB_MSK_SET  = 5;
  localparam int unsigned SB_MSK_CLR  = 6;

  function automatic lvl_t code2lvl(input logic [1:0] c);
    return lvl_t'({2'b00, c, 6'b000000});
  endfunction

  // clear beats set
  function automatic logic nxt(input logic q, input logic set, input logic clr);
    return (q | set) & ~clr;
  endfunction

  // exception number of programmable entry e
  function automatic int unsigned ent_num(input int unsigned e);
    case (e)
      0:       return EXC_SVC;
      1:       return EXC_PSV;
      2:       return EXC_TICK;
      default: return EXC_EXT0 + e - 3;
    endcase
  endfunction
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned NUM_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic [NUM_IRQ-1:0] ena_set_i,
  input  logic [NUM_IRQ-1:0] ena_clr_i,
  input  logic [NUM_IRQ-1:0] pnd_set_i,
  input  logic [NUM_IRQ-1:0] pnd_clr_i,
  input  logic               ack_i,
  input  logic [NUM_W-1:0]   ack_num_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] en_o
);
  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    logic ack_hit;
    assign ack_hit = ack_i && (ack_num_i == NUM_W'(EXC_EXT0 + k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_o[k] <= 1'b0;
        en_o[k]   <= 1'b0;
      end else begin
        pend_o[k] <= nxt(pend_o[k], irq_i[k] | pnd_set_i[k], pnd_clr_i[k] | ack_hit);
        en_o[k]   <= nxt(en_o[k], ena_set_i[k], ena_clr_i[k]);
      end
    end
  end
endmodule

// File: rtl/irq_prio_file.sv
module irq_prio_file
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned NUM_W   = 6,
  localparam int unsigned NENT   = NUM_IRQ + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [NUM_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_code_i,
  output logic [1:0]       code_o [NENT]
);
  for (genvar e = 0; e < NENT; e++) begin : g_ent
    localparam int unsigned IDX = ent_num(e);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    code_o[e] <= 2'b00;
      else if (wr_en_i && wr_idx_i == NUM_W'(IDX))    code_o[e] <= wr_code_i;
    end
  end
endmodule

// File: rtl/irq_sys_state.sv
module irq_sys_state
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             hf_req_i,
  input  logic             svc_req_i,
  input  logic             tick_req_i,
  input  logic             sys_wr_i,
  input  logic [6:0]       sys_bits_i,
  input  logic             ack_i,
  input  logic [NUM_W-1:0] ack_num_i,
  input  lvl_t             svc_lvl_i,
  input  lvl_t             cur_prio_i,
  output logic             nmi_pend_o,
  output logic             hf_pend_o,
  output logic             svc_pend_o,
  output logic             psv_pend_o,
  output logic             tick_pend_o,
  output logic             tick_en_o,
  output logic             mask_o
);
  logic [6:0] sb;
  logic svc_esc, svc_ok;
  logic ack_nmi, ack_hf, ack_svc, ack_psv, ack_tick;

  assign sb       = sys_wr_i ? sys_bits_i : 7'b0;
  // current priority at or above the call's own level
  assign svc_esc  = svc_req_i && (svc_lvl_i >= cur_prio_i);
  assign svc_ok   = svc_req_i && !svc_esc;
  assign ack_nmi  = ack_i && ack_num_i == NUM_W'(EXC_NMI);
  assign ack_hf   = ack_i && ack_num_i == NUM_W'(EXC_HF);
  assign ack_svc  = ack_i && ack_num_i == NUM_W'(EXC_SVC);
  assign ack_psv  = ack_i && ack_num_i == NUM_W'(EXC_PSV);
  assign ack_tick = ack_i && ack_num_i == NUM_W'(EXC_TICK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_pend_o  <= 1'b0;
      hf_pend_o   <= 1'b0;
      svc_pend_o  <= 1'b0;
      psv_pend_o  <= 1'b0;
      tick_pend_o <= 1'b0;
      tick_en_o   <= 1'b0;
      mask_o      <= 1'b0;
    end else begin
      nmi_pend_o  <= nxt(nmi_pend_o, nmi_i, ack_nmi);
      hf_pend_o   <= nxt(hf_pend_o, hf_req_i | svc_esc, ack_hf);
      svc_pend_o  <= nxt(svc_pend_o, svc_ok, ack_svc);
      psv_pend_o  <= nxt(psv_pend_o, sb[SB_PSV_SET], sb[SB_PSV_CLR] | ack_psv);
      tick_pend_o <= nxt(tick_pend_o, tick_req_i, sb[SB_TICK_CLR] | ack_tick);
      tick_en_o   <= nxt(tick_en_o, sb[SB_TEN_SET], sb[SB_TEN_CLR]);
      mask_o      <= nxt(mask_o, sb[SB_MSK_SET], sb[SB_MSK_CLR]);
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int unsigned NSRC  = 37,
  parameter int unsigned NUM_W = 6
) (
  input  logic [NSRC-1:0]  vld_i,
  input  lvl_t             lvl_i [NSRC],
  input  logic [NUM_W-1:0] num_i [NSRC],
  input  lvl_t             cur_prio_i,
  output logic             take_o,
  output logic [NUM_W-1:0] num_o,
  output lvl_t             lvl_o
);
  logic             best_v;
  lvl_t             best_l;
  logic [NUM_W-1:0] best_n;

  // sources ordered by ascending number; strict compare keeps the lower one on ties
  always_comb begin
    best_v = 1'b0;
    best_l = LVL_NONE;
    best_n = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (vld_i[i] && (!best_v || lvl_i[i] < best_l)) begin
        best_v = 1'b1;
        best_l = lvl_i[i];
        best_n = num_i[i];
      end
    end
  end

  assign num_o  = best_n;
  assign lvl_o  = best_l;
  assign take_o = best_v && (best_l < cur_prio_i);
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned NUM_W  = $clog2(EXC_EXT0 + NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               nmi_i,
  input  logic               hf_req_i,
  input  logic               svc_req_i,
  input  logic               tick_req_i,
  input  logic               wr_en_i,
  input  logic [NUM_W-1:0]   wr_idx_i,
  input  logic [31:0]        wr_data_i,
  input  logic               ack_i,
  input  logic [NUM_W-1:0]   ack_num_i,
  input  logic signed [9:0]  cur_prio_i,
  output logic               take_o,
  output logic [NUM_W-1:0]   exc_num_o,
  output logic signed [9:0]  exc_prio_o
);
  localparam int unsigned NENT = NUM_IRQ + 3;
  localparam int unsigned NSRC = NUM_IRQ + 5;

  logic sel_es, sel_ec, sel_ps, sel_pc, sel_sys;
  logic [NUM_IRQ-1:0] dat, ext_pend, ext_en;
  logic [1:0] code [NENT];
  logic nmi_pend, hf_pend, svc_pend, psv_pend, tick_pend, tick_en, mask_q;

  logic [NSRC-1:0]  vld;
  lvl_t             lvl [NSRC];
  logic [NUM_W-1:0] num [NSRC];

  assign dat     = wr_data_i[NUM_IRQ-1:0];
  assign sel_es  = wr_en_i && wr_idx_i == NUM_W'(IDX_ENA_SET);
  assign sel_ec  = wr_en_i && wr_idx_i == NUM_W'(IDX_ENA_CLR);
  assign sel_ps  = wr_en_i && wr_idx_i == NUM_W'(IDX_PND_SET);
  assign sel_pc  = wr_en_i && wr_idx_i == NUM_W'(IDX_PND_CLR);
  assign sel_sys = wr_en_i && wr_idx_i == NUM_W'(IDX_SYS);

  irq_line_bank #(.NUM_IRQ(NUM_IRQ), .NUM_W(NUM_W)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_i     (irq_i),
    .ena_set_i ({NUM_IRQ{sel_es}} & dat),
    .ena_clr_i ({NUM_IRQ{sel_ec}} & dat),
    .pnd_set_i ({NUM_IRQ{sel_ps}} & dat),
    .pnd_clr_i ({NUM_IRQ{sel_pc}} & dat),
    .ack_i     (ack_i),
    .ack_num_i (ack_num_i),
    .pend_o    (ext_pend),
    .en_o      (ext_en)
  );

  irq_prio_file #(.NUM_IRQ(NUM_IRQ), .NUM_W(NUM_W)) i_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_code_i (wr_data_i[7:6]),
    .code_o    (code)
  );

  irq_sys_state #(.NUM_W(NUM_W)) i_sys (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .nmi_i       (nmi_i),
    .hf_req_i    (hf_req_i),
    .svc_req_i   (svc_req_i),
    .tick_req_i  (tick_req_i),
    .sys_wr_i    (sel_sys),
    .sys_bits_i  (wr_data_i[6:0]),
    .ack_i       (ack_i),
    .ack_num_i   (ack_num_i),
    .svc_lvl_i   (code2lvl(code[0])),
    .cur_prio_i  (cur_prio_i),
    .nmi_pend_o  (nmi_pend),
    .hf_pend_o   (hf_pend),
    .svc_pend_o  (svc_pend),
    .psv_pend_o  (psv_pend),
    .tick_pend_o (tick_pend),
    .tick_en_o   (tick_en),
    .mask_o      (mask_q)
  );

  always_comb begin
    vld[0] = nmi_pend;             lvl[0] = LVL_NMI;           num[0] = NUM_W'(EXC_NMI);
    vld[1] = hf_pend;              lvl[1] = LVL_HF;            num[1] = NUM_W'(EXC_HF);
    vld[2] = svc_pend & ~mask_q;   lvl[2] = code2lvl(code[0]); num[2] = NUM_W'(EXC_SVC);
    vld[3] = psv_pend & ~mask_q;   lvl[3] = code2lvl(code[1]); num[3] = NUM_W'(EXC_PSV);
    vld[4] = tick_pend & tick_en & ~mask_q;
    lvl[4] = code2lvl(code[2]);    num[4] = NUM_W'(EXC_TICK);
    for (int k = 0; k < NUM_IRQ; k++) begin
      vld[5+k] = ext_pend[k] & ext_en[k] & ~mask_q;
      lvl[5+k] = code2lvl(code[3+k]);
      num[5+k] = NUM_W'(EXC_EXT0 + k);
    end
  end

  irq_pick #(.NSRC(NSRC), .NUM_W(NUM_W)) i_pick (
    .vld_i      (vld),
    .lvl_i      (lvl),
    .num_i      (num),
    .cur_prio_i (cur_prio_i),
    .take_o     (take_o),
    .num_o      (exc_num_o),
    .lvl_o      (exc_prio_o)
  );
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int unsigned NUM_IRQ = 32,
  parameter int unsigned NUM_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic               wr_en_i,
  input logic [NUM_W-1:0]   wr_idx_i,
  input logic [31:0]        wr_data_i,
  input logic               ack_i,
  input logic signed [9:0]  cur_prio_i,
  input logic               take_o,
  input logic [NUM_W-1:0]   exc_num_o,
  input logic signed [9:0]  exc_prio_o,
  input logic               mask_i,
  input logic [NUM_IRQ-1:0] pend_i
);
  assert_strict_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (exc_prio_o < cur_prio_i));

  assert_nmi_lvl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_num_o == NUM_W'(2)) |-> (exc_prio_o == -10'sd2));

  assert_hf_lvl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_num_o == NUM_W'(3)) |-> (exc_prio_o == -10'sd1));

  assert_gran_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_num_o > NUM_W'(3)) |-> (exc_prio_o[5:0] == 6'd0 && exc_prio_o >= 0 && exc_prio_o <= 10'sd192));

  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i && take_o) |-> (exc_prio_o < 0));

  assert_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i != '0 && !wr_en_i && !ack_i) |=> ((pend_i & $past(irq_i)) == $past(irq_i)));

  assert_swclr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == NUM_W'(3) && (wr_data_i[NUM_IRQ-1:0] & irq_i) == '0)
    |=> ((pend_i & $past(wr_data_i[NUM_IRQ-1:0])) == '0));

  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_num_o == '0) |-> (exc_prio_o == 10'sd256 && !take_o));
endmodule

bind irq_prio_arb irq_arb_chk #(.NUM_IRQ(NUM_IRQ), .NUM_W(NUM_W)) i_irq_arb_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .wr_en_i    (wr_en_i),
  .wr_idx_i   (wr_idx_i),
  .wr_data_i  (wr_data_i),
  .ack_i      (ack_i),
  .cur_prio_i (cur_prio_i),
  .take_o     (take_o),
  .exc_num_o  (exc_num_o),
  .exc_prio_o (exc_prio_o),
  .mask_i     (mask_q),
  .pend_i     (ext_pend)
);

// File: tb/test_irq_prio_arb.sv
`timescale 1ns/1ps
module test_irq_prio_arb;
  localparam int NI = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NI-1:0] irq_i = '0;
  logic nmi_i = 0, hf_req_i = 0, svc_req_i = 0, tick_req_i = 0;
  logic wr_en_i = 0;
  logic [5:0] wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic ack_i = 0;
  logic [5:0] ack_num_i = '0;
  logic signed [9:0] cur_prio_i = 10'sd256;
  logic take_o;
  logic [5:0] exc_num_o;
  logic signed [9:0] exc_prio_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_arb #(.NUM_IRQ(NI)) i_irq_prio_arb (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .nmi_i(nmi_i), .hf_req_i(hf_req_i),
    .svc_req_i(svc_req_i), .tick_req_i(tick_req_i), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
    .wr_data_i(wr_data_i), .ack_i(ack_i), .ack_num_i(ack_num_i), .cur_prio_i(cur_prio_i),
    .take_o(take_o), .exc_num_o(exc_num_o), .exc_prio_o(exc_prio_o));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic expect3(string tag, int tk, int n, int p);
    chk({tag, " take"}, int'(take_o), tk);
    chk({tag, " num"}, int'(exc_num_o), n);
    chk({tag, " prio"}, int'(exc_prio_o), p);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(int idx, logic [31:0] d);
    wr_en_i = 1; wr_idx_i = idx[5:0]; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic pulse_irq(int k);
    irq_i[k] = 1'b1;
    @(negedge clk);
    irq_i[k] = 1'b0;
  endtask

  task automatic ack(int n);
    ack_i = 1; ack_num_i = n[5:0];
    @(negedge clk);
    ack_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle();
    expect3("R12 reset", 0, 0, 256);

    // every line: pulse while disabled, enable, ack, disable
    for (int k = 0; k < NI; k++) begin
      wr(16 + k, 32'((k % 4) * 64 + 63));
      pulse_irq(k);
      expect3("R6 disabled held", 0, 0, 256);
      wr(0, 32'(1) << k);
      expect3("R1 R3 R7 line", 1, 16 + k, (k % 4) * 64);
      ack(16 + k);
      expect3("R11 ack clears", 0, 0, 256);
      wr(1, 32'(1) << k);
    end

    // strict preemption
    wr(21, 32'h80); wr(0, 32'(1) << 5); pulse_irq(5);
    cur_prio_i = 10'sd128; idle();
    expect3("R4 equal", 0, 21, 128);
    cur_prio_i = 10'sd129; idle();
    expect3("R4 lower current", 1, 21, 128);
    cur_prio_i = 10'sd64; idle();
    expect3("R4 higher current", 0, 21, 128);
    cur_prio_i = 10'sd256; idle();
    expect3("R4 thread", 1, 21, 128);
    wr(3, 32'(1) << 5);
    expect3("R9 sw clear", 0, 0, 256);
    wr(1, 32'(1) << 5);

    // tie / level sweep on lines 3 and 7
    wr(0, 32'h88);
    for (int pa = 0; pa < 4; pa++) begin
      for (int pb = 0; pb < 4; pb++) begin
        wr(19, 32'(pa * 64)); wr(23, 32'(pb * 64));
        irq_i[3] = 1; irq_i[7] = 1; idle(); irq_i[3] = 0; irq_i[7] = 0;
        expect3("R5 pair", 1, (pb < pa) ? 23 : 19, ((pb < pa) ? pb : pa) * 64);
        wr(3, 32'h88);
      end
    end
    wr(1, 32'hFFFF_FFFF);

    // system call vs line 0 at same level
    wr(16, 32'h40); wr(0, 32'h1); wr(11, 32'h40);
    svc_req_i = 1; irq_i[0] = 1; idle(); svc_req_i = 0; irq_i[0] = 0;
    expect3("R5 R1 svc tie", 1, 11, 64);
    ack(11);
    expect3("R5 next line0", 1, 16, 64);
    ack(16);
    expect3("R11 empty", 0, 0, 256);
    wr(1, 32'hFFFF_FFFF);

    // mask
    wr(18, 32'h00); wr(0, 32'h4); pulse_irq(2);
    expect3("R8 unmasked", 1, 18, 0);
    wr(4, 32'h20);
    expect3("R8 masked", 0, 0, 256);
    nmi_i = 1; idle(); nmi_i = 0;
    expect3("R8 R2 nmi", 1, 2, -2);
    ack(2);
    expect3("R8 after nmi", 0, 0, 256);
    hf_req_i = 1; idle(); hf_req_i = 0;
    expect3("R8 R2 hard fault", 1, 3, -1);
    ack(3);
    wr(4, 32'h40);
    expect3("R8 unmask", 1, 18, 0);
    nmi_i = 1; idle(); nmi_i = 0;
    expect3("R2 nmi over line", 1, 2, -2);
    ack(2); ack(18);
    expect3("R11 cleared", 0, 0, 256);
    wr(1, 32'h4);

    // system call escalation
    wr(11, 32'h80);
    cur_prio_i = 10'sd128;
    svc_req_i = 1; idle(); svc_req_i = 0;
    expect3("R10 equal escalates", 1, 3, -1);
    ack(3);
    cur_prio_i = 10'sd192;
    svc_req_i = 1; idle(); svc_req_i = 0;
    expect3("R10 no escalation", 1, 11, 128);
    ack(11);
    cur_prio_i = 10'sd64;
    svc_req_i = 1; idle(); svc_req_i = 0;
    expect3("R10 higher escalates", 1, 3, -1);
    ack(3);
    cur_prio_i = 10'sd256; idle();
    expect3("R10 clean", 0, 0, 256);

    // level re-pend
    wr(25, 32'h40); wr(0, 32'(1) << 9);
    irq_i[9] = 1; idle();
    expect3("R7 level", 1, 25, 64);
    ack(25);
    expect3("R11 ack wins", 0, 0, 256);
    idle();
    expect3("R11 re-pend", 1, 25, 64);
    irq_i[9] = 0;
    ack(25); idle();
    expect3("R11 level gone", 0, 0, 256);
    wr(1, 32'(1) << 9);

    // tick and pendable service
    wr(15, 32'h40);
    tick_req_i = 1; idle(); tick_req_i = 0;
    expect3("R6 tick disabled", 0, 0, 256);
    wr(4, 32'h08);
    expect3("R6 R1 tick", 1, 15, 64);
    wr(14, 32'h40); wr(4, 32'h01);
    expect3("R5 R1 pendsv tie", 1, 14, 64);
    wr(4, 32'h02);
    expect3("R9 pendsv clear", 1, 15, 64);
    wr(4, 32'h04);
    expect3("R9 tick clear", 0, 0, 256);

    // cleared before enable never shows
    pulse_irq(12); wr(3, 32'(1) << 12); wr(0, 32'(1) << 12);
    expect3("R9 cleared before enable", 0, 0, 256);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule